// File: doc/BRIEF.md
# Character LCD Power-Up and Message Sequencer

This block brings a parallel-bus character LCD out of power-up with no help from software. It then writes one fixed greeting to the display. After reset it holds off for the panel's power-on settling time. It then steps a 4-bit index through sixteen preset register-select/data words: seven configuration commands followed by the nine characters of `Hello all`. Each word goes out through an internal write-strobe generator. That generator gives the data a setup interval and then drives an enable pulse of guaranteed width.

After each strobe the sequencer waits out the execution time of that particular word. The wait comes from one counter in a bank of timeout counters, chosen by the same index that picks the word. A counter has finished when it reaches all ones. Each counter is preloaded so that its wait is never shorter than the number of clock cycles set for it. All intervals are parameters in clock cycles: the defaults suit a 50 MHz clock, and a simulation can pass scaled-down counts.

Once the last word's wait has elapsed, the sequencer parks in a terminal state with a finished flag raised. It stays there until the next reset. The message cannot be changed at run time, and the busy flag is never read, so the bus is write-only.

Top module: `lcd_msg_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it: `lcd_en`, `wr_start` and `finished` are low, the index is 0, and the outputs show the first word (`lcd_rs`=0, `lcd_data`=0x38).
- R2: The first rising edge of `lcd_en` after reset release comes no earlier than `PWR_CYC` cycles later.
- R3: Words 0 to 6 are commands with `lcd_rs`=0 (0 selects the instruction register), issued in this order: 0x38, 0x38, 0x38, 0x38, 0x0F, 0x01, 0x06. The index advances by exactly one per load-next step.
- R4: Words 7 to 15 are characters with `lcd_rs`=1 (1 selects the data register), issued in this order: 0x48, 0x65, 0x6C, 0x6C, 0x6F, 0x20, 0x61, 0x6C, 0x6C ("Hello all").
- R5: The gap from each `lcd_en` falling edge to the next rising edge is at least the wait for the word just written. That wait is `LONG_CYC` after word 0, `MID_CYC` after word 1, `CLR_CYC` after word 5 (the clear command), and `SHORT_CYC` after every other word.
- R6: `lcd_rs`/`lcd_data` are stable for at least `SETUP_CYC` cycles before each `lcd_en` rise. They stay unchanged while `lcd_en` is high and on the cycle after its fall.
- R7: Every `lcd_en` pulse lasts at least `PULSE_CYC` cycles.
- R8: `finished` rises only after word 15 and no earlier than `SHORT_CYC` cycles after its strobe ends. It then stays high, with no further `lcd_en` or `wr_start` activity.
- R9: `wr_start` is a one-cycle pulse, issued exactly once per word: sixteen pulses per run.
- R10: Reset asserted in the middle of the sequence restarts it from word 0, including the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 50 MHz nominal |
| rst | input | 1 | Synchronous reset, active high |
| lcd_rs | output | 1 | Register select of the current word (0 command, 1 character) |
| lcd_data | output | 8 | Data byte of the current word |
| lcd_en | output | 1 | Write enable strobe to the panel |
| wr_start | output | 1 | One-cycle pulse when a word's write begins |
| finished | output | 1 | High once the whole message has been written |

## Verification
The bench targets three kinds of fault:
- Waits that differ by word. A wait bank that picks the wrong counter for word 0, word 1 or the clear command would let the following strobe arrive too early. The bench measures every gap against the wait owed for that word.
- Counter sizing. Preload arithmetic that rounds a count down to a power of two would shorten the power-up delay or a pulse, and the bench catches both.
- The last word. An off-by-one at the end would drop the final character or raise `finished` before the last wait has elapsed.

It also resets in the middle of a run. A sequencer that kept its index, or skipped the power-up delay, would resume partway through the message.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int NUM_WORDS = 16;
  localparam int IDX_W     = 4;
  localparam int NUM_CLS   = 5;

  // wait classes, one timeout counter each
  localparam int CLS_PWR   = 0;
  localparam int CLS_LONG  = 1;
  localparam int CLS_MID   = 2;
  localparam int CLS_CLR   = 3;
  localparam int CLS_SHORT = 4;

  typedef enum logic [2:0] {
    SQ_PWRUP, SQ_PWRUP_WAIT, SQ_WRITE, SQ_STROBE, SQ_EXEC, SQ_NEXT, SQ_END
  } seq_state_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_DONE
  } stb_state_t;

  typedef struct packed {
    logic       rs;
    logic [7:0] code;
  } lcd_word_t;

  // bits needed so that all-ones is at least n-1 counts above the preload
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // preload so that counting up to all ones takes exactly n enabled cycles
  function automatic int preload(input int n, input int w);
    return (1 << w) - n;
  endfunction

  function automatic int wait_class(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return CLS_LONG;
      4'd1:    return CLS_MID;
      4'd5:    return CLS_CLR;
      default: return CLS_SHORT;
    endcase
  endfunction

  function automatic lcd_word_t word_at(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0, 4'd1, 4'd2, 4'd3: return '{rs: 1'b0, code: 8'h38};
      4'd4:  return '{rs: 1'b0, code: 8'h0F};
      4'd5:  return '{rs: 1'b0, code: 8'h01};
      4'd6:  return '{rs: 1'b0, code: 8'h06};
      4'd7:  return '{rs: 1'b1, code: 8'h48};
      4'd8:  return '{rs: 1'b1, code: 8'h65};
      4'd9, 4'd10, 4'd14, 4'd15: return '{rs: 1'b1, code: 8'h6C};
      4'd11: return '{rs: 1'b1, code: 8'h6F};
      4'd12: return '{rs: 1'b1, code: 8'h20};
      default: return '{rs: 1'b1, code: 8'h61};
    endcase
  endfunction

endpackage

// File: rtl/lcd_word_rom.sv
module lcd_word_rom
  import lcd_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic             rs,
  output logic [7:0]       code
);
  lcd_word_t word;

  always_comb word = word_at(idx);

  assign rs   = word.rs;
  assign code = word.code;
endmodule

// File: rtl/lcd_wait_bank.sv
module lcd_wait_bank
  import lcd_seq_pkg::*;
#(
  parameter int PWR_CYC   = 2250000,
  parameter int LONG_CYC  = 205000,
  parameter int MID_CYC   = 5000,
  parameter int CLR_CYC   = 82000,
  parameter int SHORT_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_run,
  input  logic             exec_run,
  input  logic [IDX_W-1:0] idx,
  output logic             timeout
);
  localparam int CYCS [NUM_CLS] = '{PWR_CYC, LONG_CYC, MID_CYC, CLR_CYC, SHORT_CYC};

  logic [NUM_CLS-1:0] run;
  logic [NUM_CLS-1:0] hit;
  int                 sel_cls;

  always_comb sel_cls = wait_class(idx);

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cnt
    localparam int          W    = cnt_width(CYCS[g]);
    localparam logic [W-1:0] LOAD = W'(preload(CYCS[g], W));
    logic [W-1:0] cnt;

    if (g == CLS_PWR) begin : g_pwr
      assign run[g] = pwr_run;
    end else begin : g_exec
      assign run[g] = exec_run && (sel_cls == g);
    end

    always_ff @(posedge clk) begin
      if (rst || !run[g])   cnt <= LOAD;
      else if (!(&cnt))     cnt <= cnt + 1'b1;
    end

    assign hit[g] = &cnt;
  end

  assign timeout = |(hit & run);
endmodule

// File: rtl/lcd_write_strobe.sv
module lcd_write_strobe
  import lcd_seq_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic en,
  output logic done
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CW   = cnt_width(MAXC);

  stb_state_t    state;
  logic [CW-1:0] cnt;
  logic          setup_last;
  logic          high_last;

  assign setup_last = (cnt == CW'(SETUP_CYC - 1));
  assign high_last  = (cnt == CW'(PULSE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_last) begin
            state <= ST_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (high_last) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign en   = (state == ST_HIGH);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/lcd_msg_sequencer.sv
module lcd_msg_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int PWR_CYC   = 2250000,
  parameter int LONG_CYC  = 205000,
  parameter int MID_CYC   = 5000,
  parameter int CLR_CYC   = 82000,
  parameter int SHORT_CYC = 2000,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 12
) (
  input  logic       clk,
  input  logic       rst,
  output logic       lcd_rs,
  output logic [7:0] lcd_data,
  output logic       lcd_en,
  output logic       wr_start,
  output logic       finished
);
  seq_state_t       state;
  logic [IDX_W-1:0] idx;

  // named internal events
  logic wait_done;
  logic stb_done;
  logic step_next;
  logic last_word;

  assign step_next = (state == SQ_NEXT);
  assign last_word = (idx == IDX_W'(NUM_WORDS - 1));
  assign wr_start  = (state == SQ_WRITE);
  assign finished  = (state == SQ_END);

  lcd_word_rom i_rom (
    .idx  (idx),
    .rs   (lcd_rs),
    .code (lcd_data)
  );

  lcd_wait_bank #(
    .PWR_CYC   (PWR_CYC),
    .LONG_CYC  (LONG_CYC),
    .MID_CYC   (MID_CYC),
    .CLR_CYC   (CLR_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) i_waits (
    .clk      (clk),
    .rst      (rst),
    .pwr_run  (state == SQ_PWRUP_WAIT),
    .exec_run (state == SQ_EXEC),
    .idx      (idx),
    .timeout  (wait_done)
  );

  lcd_write_strobe #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) i_strobe (
    .clk   (clk),
    .rst   (rst),
    .start (wr_start),
    .en    (lcd_en),
    .done  (stb_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_PWRUP;
      idx   <= '0;
    end else begin
      case (state)
        SQ_PWRUP:      state <= SQ_PWRUP_WAIT;
        SQ_PWRUP_WAIT: if (wait_done) state <= SQ_WRITE;
        SQ_WRITE:      state <= SQ_STROBE;
        SQ_STROBE:     if (stb_done) state <= SQ_EXEC;
        SQ_EXEC:       if (wait_done) state <= SQ_NEXT;
        SQ_NEXT: begin
          if (last_word) begin
            state <= SQ_END;
          end else begin
            idx   <= idx + 1'b1;
            state <= SQ_WRITE;
          end
        end
        default:       state <= SQ_END;
      endcase
    end
  end
endmodule

// File: rtl/lcd_msg_sequencer_chk.sv
module lcd_msg_sequencer_chk #(
  parameter int PWR_CYC   = 2250000,
  parameter int PULSE_CYC = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       lcd_rs,
  input logic [7:0] lcd_data,
  input logic       lcd_en,
  input logic       wr_start,
  input logic       finished,
  input logic       step_next,
  input logic       last_word,
  input logic [3:0] idx
);
  int unsigned since_rst;
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                               since_rst <= 0;
    else if (since_rst < PWR_CYC)          since_rst <= since_rst + 1;
  end

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= 0;
    else if (lcd_en)  hi_cnt <= (hi_cnt < PULSE_CYC) ? hi_cnt + 1 : hi_cnt;
    else              hi_cnt <= 0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!lcd_en && !wr_start && !finished && idx == 4'd0));

  a_r2_pwrup_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_en) |-> since_rst >= PWR_CYC);

  a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
    (step_next && !last_word) |=> idx == $past(idx) + 4'd1);

  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
    lcd_en |=> $stable({lcd_rs, lcd_data}));

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> hi_cnt >= PULSE_CYC);

  a_r8_end_sticky: assert property (@(posedge clk) disable iff (rst)
    finished |=> (finished && !lcd_en && !wr_start));

  a_r8_end_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(finished) |-> last_word);

  a_r9_start_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> !wr_start);
endmodule

bind lcd_msg_sequencer lcd_msg_sequencer_chk #(
  .PWR_CYC   (PWR_CYC),
  .PULSE_CYC (PULSE_CYC)
) i_chk (.*);

// File: tb/test_lcd_msg_sequencer.sv
module test_lcd_msg_sequencer;
  localparam int PWR   = 300;
  localparam int LONG  = 120;
  localparam int MID   = 50;
  localparam int CLR   = 80;
  localparam int SHORT = 25;
  localparam int SETUP = 3;
  localparam int PULSE = 7;

  // expected {rs, data} and post-write wait per word
  localparam logic [8:0] EXP_WORD [16] = '{
    9'h038, 9'h038, 9'h038, 9'h038, 9'h00F, 9'h001, 9'h006,
    9'h148, 9'h165, 9'h16C, 9'h16C, 9'h16F, 9'h120, 9'h161, 9'h16C, 9'h16C};
  localparam int EXP_WAIT [16] = '{
    LONG, MID, SHORT, SHORT, SHORT, CLR, SHORT, SHORT,
    SHORT, SHORT, SHORT, SHORT, SHORT, SHORT, SHORT, SHORT};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lcd_rs;
  logic [7:0] lcd_data;
  logic       lcd_en;
  logic       wr_start;
  logic       finished;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_chg = 0;
  int n_start = 0;
  logic [8:0] prev_word = 9'h038;
  bit done_flag = 0;

  always #10 clk = ~clk;

  lcd_msg_sequencer #(
    .PWR_CYC(PWR), .LONG_CYC(LONG), .MID_CYC(MID), .CLR_CYC(CLR),
    .SHORT_CYC(SHORT), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE)
  ) i_lcd_msg_sequencer (
    .clk(clk), .rst(rst), .lcd_rs(lcd_rs), .lcd_data(lcd_data),
    .lcd_en(lcd_en), .wr_start(wr_start), .finished(finished)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if ({lcd_rs, lcd_data} !== prev_word) begin
      last_chg  = cyc;
      prev_word = {lcd_rs, lcd_data};
    end
    if (wr_start === 1'b1) n_start = n_start + 1;
  end

  task automatic check_eq(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_ge(input int act, input int min, input string req);
    checks++;
    if (act < min) begin
      errors++;
      $display("FAIL %s: actual %0d expected >= %0d", req, act, min);
    end
  endtask

  task automatic wait_en(input logic lvl, output int t);
    int n = 0;
    while (lcd_en !== lvl && n < 20000) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  task automatic check_reset_state(input string req);
    check_eq(int'(lcd_en), 0, {req, " lcd_en"});
    check_eq(int'(wr_start), 0, {req, " wr_start"});
    check_eq(int'(finished), 0, {req, " finished"});
    check_eq(int'({lcd_rs, lcd_data}), 9'h038, {req, " first word"});
  endtask

  task automatic run_sequence(input bit restart);
    int t_rel, t_rise, t_fall, t_fin, en_seen;
    @(negedge clk);
    rst = 1'b0;
    t_rel = cyc;
    n_start = 0;
    t_fall = 0;
    for (int k = 0; k < 16; k++) begin
      wait_en(1'b1, t_rise);
      // R3 / R4 word order and register select
      check_eq(int'({lcd_rs, lcd_data}), int'(EXP_WORD[k]), (k < 7) ? "R3 command" : "R4 character");
      check_ge(t_rise - last_chg, SETUP, "R6 setup");
      if (k == 0) begin
        check_ge(t_rise - t_rel, PWR, restart ? "R10 power-up after restart" : "R2 power-up");
      end else begin
        check_ge(t_rise - t_fall, EXP_WAIT[k-1], "R5 execution wait");
      end
      wait_en(1'b0, t_fall);
      check_ge(t_fall - t_rise, PULSE, "R7 pulse width");
      @(negedge clk);
      check_ge(cyc - last_chg, cyc - t_rise + 1, "R6 hold");
    end
    while (finished !== 1'b1 && (cyc - t_fall) < 2000) @(negedge clk);
    t_fin = cyc;
    check_eq(int'(finished), 1, "R8 finished raised");
    check_ge(t_fin - t_fall, EXP_WAIT[15], "R8 last wait before finished");
    en_seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (lcd_en || wr_start || !finished) en_seen++;
    end
    check_eq(en_seen, 0, "R8 quiet after end");
    check_eq(n_start, 16, "R9 start pulses");
  endtask

  initial begin
    int t;
    repeat (5) @(negedge clk);
    check_reset_state("R1");
    run_sequence(1'b0);

    // R10: reset in the middle of the run, during the wait after word 1
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_en(1'b1, t);
    wait_en(1'b0, t);
    wait_en(1'b1, t);
    wait_en(1'b0, t);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("R10 R1");
    run_sequence(1'b1);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule